// File: doc/BRIEF.md
# Nonvolatile memory access controller

This block is the control-and-status register and the sequencer that a small processor core uses to start operations on its nonvolatile storage. Three targets can be reached: program flash, data EEPROM and the configuration registers. The core writes an 8-bit control word through a write strobe, reads the same word back at any time, and supplies the memory address on a separate pointer input. The block turns accepted requests into a request to a memory model outside it and waits for that model's completion pulse.

A read request lasts exactly one cycle. A write or row erase is self-timed and ends when the memory reports completion. The request bits can be set by software but never cleared by it; only the hardware clears them. A write can start only if the write-enable bit was set by an earlier register write. If a reset lands while a write or erase is running, the error flag is set. The two target-select bits keep their values across that reset, so software can see afterwards which target was being written.

The sequencer has four states. `ST_IDLE` waits for a request. `ST_READ` lasts one cycle and always returns to `ST_IDLE`. `ST_PROG` is a plain write and `ST_ERASE` is a row erase. Each of these two returns to `ST_IDLE` on the completion pulse or on reset. The transitions are:

- `ST_IDLE` to `ST_PROG` or `ST_ERASE` when a write is accepted.
- `ST_IDLE` to `ST_READ` when a read is accepted.
- `ST_READ` to `ST_IDLE`, always, after one cycle.
- `ST_PROG` or `ST_ERASE` to `ST_IDLE` on completion or on reset.

Top module: `nvm_ctl`

## Requirements
- R1: The control word bit layout is: bit 7 = program-memory select, bit 6 = configuration select, bit 5 = unused, bit 4 = row-erase enable, bit 3 = error flag, bit 2 = write enable, bit 1 = write request, bit 0 = read request. The target seen on `mem_tgt` is 2 (configuration) when bit 6 is 1. Otherwise it is 1 (flash) when bit 7 is 1 and 0 (data EEPROM) when bit 7 is 0. The select bits used are the values held after the accepting write.
- R2: Writing 1 to bit 0 while idle, with bit 7 of the same write at 0, starts a read. For exactly the next cycle, bit 0 reads 1, `mem_req` is 1 and `mem_op` is 0 (read), and `mem_addr` equals the pointer that was sampled. In the cycle after that, bit 0 reads 0, `mem_req` is 0 and `op_done` is 1.
- R3: A read request written together with bit 7 = 1 is ignored: no request reaches the memory and bit 0 stays 0.
- R4: Writing 1 to bit 1 while idle, with write enable already 1, starts a self-timed operation. Bit 1 then reads 1 and `mem_req` stays 1 until the cycle after `mem_done` is seen. A software write of 0 to bit 1 does not clear it. With bit 4 = 0, `mem_op` is 1 (write) and `mem_addr` is the full sampled pointer.
- R5: While write enable is 0, writing 1 to bit 1 starts nothing. Bit 1 stays 0 and `mem_req` stays 0. Setting write enable in the same write does not count.
- R6: With bit 4 = 1, the write request becomes a row erase. `mem_op` is 2 (erase) and `mem_addr` has its lowest 6 bits forced to 0. Bit 4 is cleared by hardware when the erase completes.
- R7: At the clock edge where `mem_done` is seen during a write or erase, the request bits are cleared, and `op_done` is 1 for the following cycle only.
- R8: While a write or erase is running, read and write requests are ignored. Bits 7, 6 and 4 cannot be changed. Bits 3 and 2 remain writable.
- R9: A reset during a write or erase sets the error flag and keeps bits 7 and 6 unchanged. The reset clears write enable, row-erase enable and both request bits, and returns the sequencer to idle.
- R10: The error flag is written by software. A reset while idle leaves it unchanged, and a write that completes normally leaves it at 0.
- R11: Bit 5 always reads 0, even after a write of 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word read-back |
| ptr_addr | input | ADDR_W | Memory address from the core, sampled when an operation starts |
| mem_req | output | 1 | Request to the memory, high while an operation is active |
| mem_op | output | 2 | Operation: 0 read, 1 write, 2 erase |
| mem_tgt | output | 2 | Target: 0 data EEPROM, 1 flash, 2 configuration |
| mem_addr | output | ADDR_W | Address presented to the memory |
| mem_done | input | 1 | Completion pulse from the memory for writes and erases |
| op_done | output | 1 | One-cycle strobe after any operation finishes |

## Verification
The bound checker checks the following on every cycle:
- A read lasts one cycle.
- A write request holds until completion, and completion clears it and raises the done strobe.
- No write starts without enable.
- Erase addresses are row aligned.
- The select bits stay stable while a write runs.
- The target output follows the select bits.

Some behaviour spans a reset or depends on the order in which requests arrive, and only the bench scenarios show it:
- The error flag being set by a reset in mid-write.
- The select bits surviving that reset.
- Busy-time requests being ignored.
- The read gating by the program-memory select.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_PROG  = 2'd2,
        ST_ERASE = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ERASE = 2'd2
    } mem_op_t;

    typedef enum logic [1:0] {
        TGT_EEPROM = 2'd0,
        TGT_FLASH  = 2'd1,
        TGT_CONFIG = 2'd2
    } mem_tgt_t;

    localparam int CW_W  = 8;
    localparam int B_PGM = 7;
    localparam int B_CFG = 6;
    localparam int B_NIL = 5;
    localparam int B_ERS = 4;
    localparam int B_ERR = 3;
    localparam int B_WEN = 2;
    localparam int B_WR  = 1;
    localparam int B_RD  = 0;

endpackage

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [CW_W-1:0] reg_wdata,
    input  logic            wen_q,
    input  logic            mem_done,
    output seq_state_t      state_o,
    output logic            start_o,
    output logic            fin_erase_o,
    output logic            done_o
);

    seq_state_t state_q, state_d;
    logic       done_d;
    logic       wr_accept, rd_accept;

    // write has priority over a read requested in the same word
    assign wr_accept = reg_we && reg_wdata[B_WR] && wen_q;
    assign rd_accept = reg_we && reg_wdata[B_RD] && !reg_wdata[B_PGM];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_o  <= done_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        done_d      = 1'b0;
        start_o     = 1'b0;
        fin_erase_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_accept) begin
                    state_d = reg_wdata[B_ERS] ? ST_ERASE : ST_PROG;
                    start_o = 1'b1;
                end else if (rd_accept) begin
                    state_d = ST_READ;
                    start_o = 1'b1;
                end
            end
            ST_READ: begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
            end
            ST_PROG: begin
                if (mem_done) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            ST_ERASE: begin
                if (mem_done) begin
                    state_d     = ST_IDLE;
                    done_d      = 1'b1;
                    fin_erase_o = 1'b1;
                end
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/nvm_csr.sv
module nvm_csr
    import nvm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [CW_W-1:0] reg_wdata,
    input  seq_state_t      state_i,
    input  logic            fin_erase_i,
    output logic            pgm_q,
    output logic            cfg_q,
    output logic            ers_q,
    output logic            wen_q,
    output logic [CW_W-1:0] reg_rdata
);

    logic idle, wr_busy, rd_busy, err_q;

    assign idle    = (state_i == ST_IDLE);
    assign rd_busy = (state_i == ST_READ);
    assign wr_busy = (state_i == ST_PROG) || (state_i == ST_ERASE);

    // select bits: no reset, frozen while any operation runs
    always_ff @(posedge clk) begin
        if (!rst && reg_we && idle) begin
            pgm_q <= reg_wdata[B_PGM];
            cfg_q <= reg_wdata[B_CFG];
        end
    end

    // error flag: set by a reset that cuts a write short, else software owned
    always_ff @(posedge clk) begin
        if (rst) begin
            if (wr_busy) err_q <= 1'b1;
        end else if (reg_we) begin
            err_q <= reg_wdata[B_ERR];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         wen_q <= 1'b0;
        else if (reg_we) wen_q <= reg_wdata[B_WEN];
    end

    always_ff @(posedge clk) begin
        if (rst)                ers_q <= 1'b0;
        else if (fin_erase_i)   ers_q <= 1'b0;
        else if (reg_we && idle) ers_q <= reg_wdata[B_ERS];
    end

    always_comb begin
        reg_rdata        = '0;
        reg_rdata[B_PGM] = pgm_q;
        reg_rdata[B_CFG] = cfg_q;
        reg_rdata[B_NIL] = 1'b0;
        reg_rdata[B_ERS] = ers_q;
        reg_rdata[B_ERR] = err_q;
        reg_rdata[B_WEN] = wen_q;
        reg_rdata[B_WR]  = wr_busy;
        reg_rdata[B_RD]  = rd_busy;
    end

endmodule

// File: rtl/nvm_req.sv
module nvm_req
    import nvm_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int ROW_BITS = 6
) (
    input  logic              clk,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] ptr_addr,
    input  seq_state_t        state_i,
    input  logic              pgm_i,
    input  logic              cfg_i,
    output logic              mem_req,
    output logic [1:0]        mem_op,
    output logic [1:0]        mem_tgt,
    output logic [ADDR_W-1:0] mem_addr
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] row_addr;
    mem_op_t           op;
    mem_tgt_t          tgt;

    always_ff @(posedge clk) begin
        if (start_i) addr_q <= ptr_addr;
    end

    generate
        if (ROW_BITS > 0) begin : g_row_mask
            localparam logic [ADDR_W-1:0] ROW_MASK = {{(ADDR_W-ROW_BITS){1'b1}}, {ROW_BITS{1'b0}}};
            assign row_addr = addr_q & ROW_MASK;
        end else begin : g_no_mask
            assign row_addr = addr_q;
        end
    endgenerate

    always_comb begin
        unique case (state_i)
            ST_IDLE:  op = OP_READ;
            ST_READ:  op = OP_READ;
            ST_PROG:  op = OP_WRITE;
            ST_ERASE: op = OP_ERASE;
        endcase
    end

    always_comb begin
        if (cfg_i)      tgt = TGT_CONFIG;
        else if (pgm_i) tgt = TGT_FLASH;
        else            tgt = TGT_EEPROM;
    end

    assign mem_req  = (state_i != ST_IDLE);
    assign mem_op   = op;
    assign mem_tgt  = tgt;
    assign mem_addr = (state_i == ST_ERASE) ? row_addr : addr_q;

endmodule

// File: rtl/nvm_ctl.sv
module nvm_ctl
    import nvm_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int ROW_BITS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [ADDR_W-1:0] ptr_addr,
    output logic              mem_req,
    output logic [1:0]        mem_op,
    output logic [1:0]        mem_tgt,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_done,
    output logic              op_done
);

    seq_state_t state;
    logic       start, fin_erase;
    logic       pgm_q, cfg_q, ers_q, wen_q;

    nvm_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .wen_q       (wen_q),
        .mem_done    (mem_done),
        .state_o     (state),
        .start_o     (start),
        .fin_erase_o (fin_erase),
        .done_o      (op_done)
    );

    nvm_csr u_csr (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .state_i     (state),
        .fin_erase_i (fin_erase),
        .pgm_q       (pgm_q),
        .cfg_q       (cfg_q),
        .ers_q       (ers_q),
        .wen_q       (wen_q),
        .reg_rdata   (reg_rdata)
    );

    nvm_req #(
        .ADDR_W   (ADDR_W),
        .ROW_BITS (ROW_BITS)
    ) u_req (
        .clk      (clk),
        .start_i  (start),
        .ptr_addr (ptr_addr),
        .state_i  (state),
        .pgm_i    (pgm_q),
        .cfg_i    (cfg_q),
        .mem_req  (mem_req),
        .mem_op   (mem_op),
        .mem_tgt  (mem_tgt),
        .mem_addr (mem_addr)
    );

endmodule

// File: rtl/nvm_ctl_chk.sv
module nvm_ctl_chk #(
    parameter int ADDR_W   = 16,
    parameter int ROW_BITS = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [7:0]        reg_rdata,
    input logic              mem_req,
    input logic [1:0]        mem_op,
    input logic [1:0]        mem_tgt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_done,
    input logic              op_done
);

    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << ROW_BITS) - 64'd1);

    assert_tgt_follows_sel_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_tgt == (reg_rdata[6] ? 2'd2 : {1'b0, reg_rdata[7]})));

    assert_read_drives_mem_R2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[0] |-> (mem_req && mem_op == 2'd0));

    assert_read_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[0] |=> !reg_rdata[0]);

    assert_write_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[1] && !mem_done) |=> (reg_rdata[1] && mem_req));

    assert_no_start_without_enable_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !reg_rdata[2] && reg_rdata[1:0] == 2'b00) |=> !reg_rdata[1]);

    assert_erase_row_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_op == 2'd2) |-> ((mem_addr & LOW_MASK) == '0));

    assert_completion_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[1] && mem_done) |=> (!reg_rdata[1] && op_done));

    assert_done_after_req_R7: assert property (@(posedge clk) disable iff (rst)
        op_done |-> $past(mem_req));

    assert_sel_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[1] && !mem_done) |=> $stable(reg_rdata[7:6]));

endmodule

bind nvm_ctl nvm_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .ROW_BITS (ROW_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .mem_req   (mem_req),
    .mem_op    (mem_op),
    .mem_tgt   (mem_tgt),
    .mem_addr  (mem_addr),
    .mem_done  (mem_done),
    .op_done   (op_done)
);

// File: tb/nvm_ctl_test.sv
`timescale 1ns/1ps
module nvm_ctl_test;

    localparam int AW  = 16;
    localparam int LAT = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [AW-1:0] ptr_addr = '0;
    logic          mem_req;
    logic [1:0]    mem_op;
    logic [1:0]    mem_tgt;
    logic [AW-1:0] mem_addr;
    logic          mem_done = 1'b0;
    logic          op_done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    nvm_ctl #(.ADDR_W(AW), .ROW_BITS(6)) uut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ptr_addr  (ptr_addr),
        .mem_req   (mem_req),
        .mem_op    (mem_op),
        .mem_tgt   (mem_tgt),
        .mem_addr  (mem_addr),
        .mem_done  (mem_done),
        .op_done   (op_done)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // behavioural reference: 0 idle, 1 read, 2 write, 3 erase
    int            m_st = 0;
    bit            m_pgm, m_cfg, m_ers, m_err, m_wen, m_done, m_known, m_live;
    logic [AW-1:0] m_addr = '0;

    always @(posedge clk) begin
        int  o_st;
        bit  o_wen, n_done;
        cyc++;
        m_live = 1'b1;
        if (rst) begin
            if (m_st >= 2) m_err = 1'b1;
            m_st = 0; m_wen = 0; m_ers = 0; m_done = 0;
        end else begin
            o_st = m_st; o_wen = m_wen; n_done = 0;
            if (o_st == 1) begin
                m_st = 0; n_done = 1;
            end else if (o_st >= 2 && mem_done) begin
                if (o_st == 3) m_ers = 0;
                m_st = 0; n_done = 1;
            end
            if (reg_we) begin
                m_err = reg_wdata[3]; m_wen = reg_wdata[2]; m_known = 1;
                if (o_st == 0) begin
                    m_pgm = reg_wdata[7]; m_cfg = reg_wdata[6]; m_ers = reg_wdata[4];
                    if (reg_wdata[1] && o_wen) begin
                        m_st = reg_wdata[4] ? 3 : 2; m_addr = ptr_addr;
                    end else if (reg_wdata[0] && !reg_wdata[7]) begin
                        m_st = 1; m_addr = ptr_addr;
                    end
                end
            end
            m_done = n_done;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        logic [7:0] e_rd, mask;
        if (m_live) begin
            e_rd = {m_pgm, m_cfg, 1'b0, m_ers, m_err, m_wen, m_st >= 2, m_st == 1};
            mask = m_known ? 8'hFF : 8'h37;
            check("R11 model reg_rdata", {24'd0, reg_rdata & mask}, {24'd0, e_rd & mask});
            check("R4 model mem_req", {31'd0, mem_req}, {31'd0, m_st != 0});
            check("R7 model op_done", {31'd0, op_done}, {31'd0, m_done});
            if (m_st != 0) begin
                check("R6 model mem_op", {30'd0, mem_op}, (m_st == 3) ? 2 : (m_st == 2) ? 1 : 0);
                check("R6 model mem_addr", {16'd0, mem_addr},
                      {16'd0, (m_st == 3) ? (m_addr & 16'hFFC0) : m_addr});
                if (m_known)
                    check("R1 model mem_tgt", {30'd0, mem_tgt}, m_cfg ? 2 : (m_pgm ? 1 : 0));
            end
        end
    end

    // memory responder: completes writes and erases after LAT cycles
    int rcnt = 0;
    always @(negedge clk) begin
        if (mem_done) begin
            mem_done = 1'b0; rcnt = 0;
        end else if (mem_req && mem_op != 2'd0 && !rst) begin
            rcnt++;
            if (rcnt >= LAT) mem_done = 1'b1;
        end else begin
            rcnt = 0;
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    task automatic wr(input logic [7:0] d, input logic [AW-1:0] a);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = d; ptr_addr = a;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse_rst();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (op_done) break;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R9 reset state bits", {24'd0, reg_rdata & 8'h37}, 0);
        check("R9 reset no request", {31'd0, mem_req}, 0);

        wr(8'h00, 16'h0000);
        check("R10 err writable clear", {24'd0, reg_rdata}, 8'h00);

        wr(8'h01, 16'h0033);
        check("R2 read bit set", {24'd0, reg_rdata}, 8'h01);
        check("R2 read op", {29'd0, mem_req, mem_op}, 3'b100);
        check("R2 read addr", {16'd0, mem_addr}, 16'h0033);
        check("R1 eeprom target", {30'd0, mem_tgt}, 0);
        @(negedge clk);
        check("R2 read bit self clears", {24'd0, reg_rdata}, 8'h00);
        check("R2 read done strobe", {31'd0, op_done}, 1);
        @(negedge clk);
        check("R7 done one cycle", {31'd0, op_done}, 0);

        wr(8'h81, 16'h0010);
        check("R3 read blocked by pgm select", {24'd0, reg_rdata}, 8'h80);
        check("R3 no request", {31'd0, mem_req}, 0);

        wr(8'h41, 16'h0020);
        check("R1 config target", {30'd0, mem_tgt}, 2);
        @(negedge clk);

        wr(8'h20, 16'h0000);
        check("R11 unused bit reads zero", {24'd0, reg_rdata}, 8'h00);

        wr(8'h06, 16'h0055);
        check("R5 write blocked without enable", {24'd0, reg_rdata}, 8'h04);
        check("R5 no request", {31'd0, mem_req}, 0);

        wr(8'h86, 16'h1234);
        check("R4 write started", {24'd0, reg_rdata}, 8'h86);
        check("R4 write op", {30'd0, mem_op}, 1);
        check("R4 full addr", {16'd0, mem_addr}, 16'h1234);
        check("R1 flash target", {30'd0, mem_tgt}, 1);
        wr(8'h05, 16'h0000);
        check("R8 busy writes ignored", {24'd0, reg_rdata}, 8'h86);
        wait_done();
        check("R7 completion strobe", {31'd0, op_done}, 1);
        check("R7 request cleared", {24'd0, reg_rdata}, 8'h84);

        wr(8'h16, 16'h12FF);
        check("R6 erase op", {30'd0, mem_op}, 2);
        check("R6 row aligned addr", {16'd0, mem_addr}, 16'h12C0);
        wait_done();
        check("R6 erase bit cleared", {24'd0, reg_rdata}, 8'h04);
        check("R10 normal write leaves err 0", {31'd0, reg_rdata[3]}, 0);

        wr(8'hC6, 16'h0040);
        check("R1 config write target", {30'd0, mem_tgt}, 2);
        pulse_rst();
        check("R9 interrupted write", {24'd0, reg_rdata}, 8'hC8);
        check("R9 request dropped", {31'd0, mem_req}, 0);

        wr(8'hC0, 16'h0000);
        pulse_rst();
        check("R10 idle reset keeps err 0", {24'd0, reg_rdata}, 8'hC0);
        wr(8'h08, 16'h0000);
        pulse_rst();
        check("R10 idle reset keeps err 1", {24'd0, reg_rdata}, 8'h08);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule